// File: doc/BRIEF.md
# Isolated Digital I/O Port Register Block

This block is the register front end of a digital I/O card that has sixteen drive outputs and sixteen isolated inputs. A host reaches it through an eight-byte window. Each access is one byte wide and uses separate read and write strobes. Two write-only byte registers hold the output drive. Two read-only byte registers show the input lines after they pass through a synchronizer.

The inputs are also watched for a change of state. Any rising or falling edge on any synchronized input line sets a sticky pending flag, provided the interrupt is enabled. The interrupt line shows that flag, gated by the enable. The host controls the interrupt only through side effects of ordinary data offsets:
- A read of offset 2 turns interrupts on.
- Any write to offset 2 turns them off.
- Any write to offset 1 drops the pending flag. If a new edge arrives in the same cycle, the edge takes precedence.

Top module: `dio_port_regs`

## Requirements
- R1: After reset, both output bytes drive all ones (drive_out = 16'hFFFF), irq_out is low, interrupts are disabled and the pending flag is clear.
- R2: A write at offset 0 loads bus_wdata into drive_out[7:0], and a write at offset 4 loads it into drive_out[15:8]. The change is visible one clock after the strobe, and the other byte is left unchanged.
- R3: A read at offset 1 returns the synchronized input lines 7..0 on bus_rdata, and a read at offset 5 returns lines 15..8. A change on pins_in reaches bus_rdata after two clock edges. bus_rdata is combinational from the address during a read.
- R4: A read at offsets 0, 2, 3, 4, 6 or 7 returns 8'hFF.
- R5: Writes at offsets 3, 5, 6 and 7 leave drive_out and irq_out unchanged.
- R6: A read at offset 2 enables interrupts. While interrupts are enabled, a rising or falling edge on any input line raises irq_out at the third clock edge after pins_in changes, and not before.
- R7: Any write at offset 2 disables interrupts, and irq_out is low one clock later. Edges that occur while interrupts are disabled never set the pending flag, so irq_out stays low after interrupts are enabled again.
- R8: Any write at offset 1, whatever its data, clears the pending flag, and irq_out is low one clock later.
- R9: If a clear write at offset 1 falls in the same cycle as a detected input edge while interrupts are enabled, the flag stays set and irq_out stays high.
- R10: Once set, irq_out stays high until a write at offset 1 or offset 2, even if the inputs stay still.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pins_in | input | 16 | Asynchronous isolated input lines |
| drive_out | output | 16 | Output drive lines |
| irq_out | output | 1 | Change-of-state interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit lanes, two lanes and two synchronizer stages. With these values the whole eight-byte window, both output and both input lanes, and the exact three-edge latency from a pin change to the interrupt can all be checked. The two-stage chain also makes it possible to line a clear write up with the one cycle in which an edge is flagged. That alignment is how the same-cycle precedence case is tested.

// File: rtl/dio_pkg.sv
// Shared offsets and helpers for the isolated I/O port register block.
// Assumes a fixed eight-byte window in which output lane n sits at 4n and
// input lane n at 4n+1.
package dio_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_IRQ_CTL = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_IRQ_ACK = 3'd1;

    // Offset of output lane l.
    function automatic logic [ADDR_W-1:0] out_ofs(input int l);
        return ADDR_W'(l * 4);
    endfunction

    // Offset of input lane l.
    function automatic logic [ADDR_W-1:0] in_ofs(input int l);
        return ADDR_W'(l * 4 + 1);
    endfunction
endpackage

// File: rtl/dio_in_sync.sv
// Multi-stage synchronizer for the input lines, followed by a change detector.
// Assumes pins are asynchronous. edge_any is high for the one cycle in which
// the synchronized value differs from its value one cycle earlier.
module dio_in_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] sync_q,
    output logic             edge_any
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    // Shift the pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= pins;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_q = chain[STAGES-1];

    // Hold the synchronized value from one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q;
    end

    // Flag any bit that changed, whichever way it moved.
    always_comb edge_any = |(sync_q ^ prev_q);
endmodule

// File: rtl/dio_out_lane.sv
// One byte of output drive, loaded on a decoded write strobe.
// Assumes the strobe is already qualified by address.
module dio_out_lane #(
    parameter int          BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] RESET_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] q
);
    // Latch the write data, or return to the reset level.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= RESET_VAL;
        else if (load) q <= wdata;
    end
endmodule

// File: rtl/dio_irq_ctrl.sv
// Interrupt enable plus a sticky pending flag for change-of-state events.
// Assumes edge_any is a one-cycle pulse. A new edge beats a clear in the same
// cycle, and a disable beats an enable in the same cycle.
module dio_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic pend_clr,
    input  logic edge_any,
    output logic irq_en,
    output logic irq_out
);
    logic pending;

    // Track the enable, which reads and writes of the control offset drive.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_en <= 1'b0;
        else if (en_clr) irq_en <= 1'b0;
        else if (en_set) irq_en <= 1'b1;
    end

    // Set on an enabled edge and hold until a clear; the edge wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pending <= 1'b0;
        else if (edge_any && irq_en) pending <= 1'b1;
        else if (pend_clr)           pending <= 1'b0;
    end

    // Gate the pending flag with the enable.
    always_comb irq_out = pending & irq_en;
endmodule

// File: rtl/dio_port_regs.sv
// Top of the isolated I/O port register block: decodes the byte window, holds
// the output lanes, and exposes synchronized inputs and a change interrupt.
// Assumes at most one strobe per cycle from a single host, with two lanes
// fitting the eight-byte window.
module dio_port_regs #(
    parameter int BYTE_W      = 8,
    parameter int LANES       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [dio_pkg::ADDR_W-1:0]    bus_addr,
    input  logic                          bus_rd,
    input  logic                          bus_wr,
    input  logic [BYTE_W-1:0]             bus_wdata,
    output logic [BYTE_W-1:0]             bus_rdata,
    input  logic [BYTE_W*LANES-1:0]       pins_in,
    output logic [BYTE_W*LANES-1:0]       drive_out,
    output logic                          irq_out
);
    import dio_pkg::*;

    localparam int LINES = BYTE_W * LANES;

    logic [LINES-1:0] sync_q;
    logic             edge_any;
    logic             irq_en;
    logic             ctl_rd, ctl_wr, ack_wr;

    dio_in_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) in_sync_i (
        .clk(clk), .rst_n(rst_n), .pins(pins_in),
        .sync_q(sync_q), .edge_any(edge_any)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic load;
        // Decode the write strobe for this output lane.
        always_comb load = bus_wr && (bus_addr == out_ofs(l));
        dio_out_lane #(.BYTE_W(BYTE_W), .RESET_VAL('1)) lane_i (
            .clk(clk), .rst_n(rst_n), .load(load), .wdata(bus_wdata),
            .q(drive_out[l*BYTE_W +: BYTE_W])
        );
    end

    // Decode the accesses that have interrupt side effects.
    always_comb begin
        ctl_rd = bus_rd && (bus_addr == OFS_IRQ_CTL);
        ctl_wr = bus_wr && (bus_addr == OFS_IRQ_CTL);
        ack_wr = bus_wr && (bus_addr == OFS_IRQ_ACK);
    end

    dio_irq_ctrl irq_i (
        .clk(clk), .rst_n(rst_n), .en_set(ctl_rd), .en_clr(ctl_wr),
        .pend_clr(ack_wr), .edge_any(edge_any), .irq_en(irq_en),
        .irq_out(irq_out)
    );

    // Select input lane data, or all ones for any other offset.
    always_comb begin
        bus_rdata = '1;
        for (int l = 0; l < LANES; l++)
            if (bus_addr == in_ofs(l)) bus_rdata = sync_q[l*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/dio_port_regs_chk.sv
// Property checker for dio_port_regs, attached by bind below.
// Assumes the bench keeps bus_addr stable while a strobe is high.
module dio_port_regs_chk #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [2:0]                bus_addr,
    input logic                      bus_rd,
    input logic                      bus_wr,
    input logic [BYTE_W-1:0]         bus_wdata,
    input logic [BYTE_W-1:0]         bus_rdata,
    input logic [BYTE_W*LANES-1:0]   drive_out,
    input logic                      irq_out,
    input logic                      edge_any,
    input logic                      irq_en
);
    p_wr_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 3'd0 |=> drive_out[BYTE_W-1:0] == $past(bus_wdata));

    p_wr_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 3'd4 |=> drive_out[2*BYTE_W-1:BYTE_W] == $past(bus_wdata));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd4)) |=> $stable(drive_out));

    p_undef_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr != 3'd1 && bus_addr != 3'd5 |-> bus_rdata == '1);

    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 3'd2 |=> !irq_out);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 3'd1 && !edge_any |=> !irq_out);

    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_any && irq_en && !(bus_wr && bus_addr == 3'd2) |=> irq_out);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && !(bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd2)) |=> irq_out);
endmodule

bind dio_port_regs dio_port_regs_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drive_out(drive_out), .irq_out(irq_out), .edge_any(edge_any),
    .irq_en(irq_en)
);

// File: tb/dio_port_regs_tb_top.sv
// Directed bench for dio_port_regs: one task per scenario.
module dio_port_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pins_in = '0;
    logic [15:0] drive_out;
    logic        irq_out;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    dio_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_in(pins_in), .drive_out(drive_out), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 drive", 32'(drive_out), 32'hFFFF);
        chk("R1 irq", 32'(irq_out), 32'h0);
    endtask

    task automatic t_out_write();
        bus_write(3'd0, 8'h5A);
        chk("R2 low lane", 32'(drive_out), 32'hFF5A);
        bus_write(3'd4, 8'h3C);
        chk("R2 high lane", 32'(drive_out), 32'h3C5A);
    endtask

    task automatic t_in_read();
        logic [7:0] d;
        @(negedge clk) pins_in = 16'hA5C3;
        wait_n(2);
        bus_read(3'd1, d);
        chk("R3 low lane", 32'(d), 32'hC3);
        bus_read(3'd5, d);
        chk("R3 high lane", 32'(d), 32'hA5);
    endtask

    task automatic t_ignored_write();
        bus_write(3'd5, 8'h00);
        bus_write(3'd3, 8'h00);
        bus_write(3'd6, 8'h11);
        bus_write(3'd7, 8'h22);
        chk("R5 drive", 32'(drive_out), 32'h3C5A);
        chk("R5 irq", 32'(irq_out), 32'h0);
    endtask

    task automatic t_undef_read();
        logic [7:0] d;
        bus_read(3'd0, d); chk("R4 ofs0", 32'(d), 32'hFF);
        bus_read(3'd3, d); chk("R4 ofs3", 32'(d), 32'hFF);
        bus_read(3'd4, d); chk("R4 ofs4", 32'(d), 32'hFF);
        bus_read(3'd6, d); chk("R4 ofs6", 32'(d), 32'hFF);
        bus_read(3'd7, d); chk("R4 ofs7", 32'(d), 32'hFF);
        bus_read(3'd2, d); chk("R4 ofs2", 32'(d), 32'hFF);
    endtask

    task automatic t_irq_edges();
        logic [7:0] d;
        bus_write(3'd2, 8'h00);
        bus_write(3'd1, 8'h00);
        bus_read(3'd2, d);
        chk("R6 quiet after enable", 32'(irq_out), 32'h0);
        @(negedge clk) pins_in[0] = ~pins_in[0];
        wait_n(2);
        chk("R6 not before third edge", 32'(irq_out), 32'h0);
        wait_n(1);
        chk("R6 raised on change", 32'(irq_out), 32'h1);
        wait_n(5);
        chk("R10 sticky", 32'(irq_out), 32'h1);
        bus_write(3'd1, 8'hFF);
        chk("R8 cleared", 32'(irq_out), 32'h0);
        @(negedge clk) pins_in[12] = ~pins_in[12];
        wait_n(3);
        chk("R6 high lane opposite edge", 32'(irq_out), 32'h1);
    endtask

    task automatic t_disable();
        logic [7:0] d;
        bus_write(3'd2, 8'h00);
        chk("R7 low after disable", 32'(irq_out), 32'h0);
        bus_write(3'd1, 8'h00);
        @(negedge clk) pins_in = ~pins_in;
        wait_n(4);
        bus_read(3'd2, d);
        wait_n(1);
        chk("R7 no latent pending", 32'(irq_out), 32'h0);
    endtask

    task automatic t_clear_race();
        @(negedge clk) pins_in[3] = ~pins_in[3];
        wait_n(3);
        chk("R9 setup", 32'(irq_out), 32'h1);
        @(negedge clk) pins_in[9] = ~pins_in[9];
        wait_n(1);
        bus_write(3'd1, 8'h00);
        chk("R9 edge wins", 32'(irq_out), 32'h1);
        bus_write(3'd1, 8'h00);
        chk("R8 clear without edge", 32'(irq_out), 32'h0);
    endtask

    initial begin
        t_reset();
        t_out_write();
        t_in_read();
        t_ignored_write();
        t_undef_read();
        t_irq_edges();
        t_disable();
        t_clear_race();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule